// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block is a register-mapped watchdog that software has to service inside a closing window. Writing a fixed start word to the control register starts it. It then loads a down-counter with the programmed preload shifted left by a fixed amount and decrements the counter on every clock. Once started it cannot be stopped by software; only the hardware reset returns it to the idle state.

Servicing takes two ordered writes to the key register, an arm word followed by a fire word. The reload happens only if the fire word arrives while the counter is at or below a threshold. The threshold is the last loaded value shifted right by an amount chosen through the window-size register, so the open window is the tail end of each period. A fire word that arrives above the threshold, or a counter that runs out, sets a sticky violation flag. Depending on the reaction register, that flag drives either a reset request or a non-maskable interrupt request until software clears it.

Top module: `win_watchdog`

## Requirements
- R1: After reset, control (0x90) reads 0, status (0x98) reads 0, counter (0xA0) reads 0, preload (0x94) reads 0xFFF, window size (0xA8) reads 0x50, reaction (0xA4) reads 0, and both `resetOut` and `nmiOut` are low.
- R2: Writing 0xA98559DA to 0x90 starts the watchdog, and 0x90 then reads 0xA98559DA. A write of any other value to 0x90, before or after the start, has no effect. Only the hardware reset stops a started watchdog.
- R3: The preload register keeps the low 12 bits of a write. On start the counter becomes preload << RELOAD_SHIFT. After that it decreases by one on each clock edge, and 0xA0 reads the current value.
- R4: Writing 0xE51A and then 0xA35C to 0x9C while the counter is at or below the threshold reloads the counter with preload << RELOAD_SHIFT on the edge that takes the second write, and the status register is left unchanged.
- R5: The threshold is the last loaded value shifted right by k. Window codes written to 0xA8 select k: 0x50 gives k=1, 0x500 gives k=2, 0x5000 gives k=3, 0x50000 gives k=4 and 0x500000 gives k=5. Any other code gives k=1.
- R6: A key write other than the expected next word (0xE51A when idle, 0xA35C when armed) returns the key sequence to idle without a reload. Key writes have no effect while the watchdog is stopped.
- R7: A 0xA35C completion while the counter is above the threshold is a violation. It sets status bit 1, no reload takes place, and the counter keeps decrementing.
- R8: When the counter steps from 1 to 0, status bit 1 is set on that same edge. The counter then stays at 0.
- R9: While status bit 1 is set, `nmiOut` is high if 0xA4 holds 0xA and `resetOut` is high otherwise. The two outputs are never high together.
- R10: Writing a word with bit 1 set to 0x98 clears status bit 1, and a write with bit 1 clear leaves it alone. A violation on the same edge as a clear leaves the bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Watchdog clock |
| rstN | input | 1 | Asynchronous active-low hardware reset |
| regWrEn | input | 1 | Register write strobe, one write per clock |
| regAddr | input | 8 | Byte address of the register being read or written |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for `regAddr`, combinational |
| resetOut | output | 1 | Reset request while a violation is pending in reset mode |
| nmiOut | output | 1 | Non-maskable interrupt request while a violation is pending in interrupt mode |

## Verification
The bench builds the block with RELOAD_SHIFT set to 4 and a 12-bit preload. A preload of 4 then gives a 64-cycle period and a preload of 1 a 16-cycle one. With periods this short, the expiry edge, every window threshold (32, 16 and 2 counts) and the cycles on either side of each threshold can be hit exactly with directed key writes. The default shift of 13 would make each period thousands of cycles long.

// File: rtl/wdw_pkg.sv
package wdw_pkg;

  localparam logic [7:0] ADR_CTRL    = 8'h90;
  localparam logic [7:0] ADR_PRELOAD = 8'h94;
  localparam logic [7:0] ADR_STATUS  = 8'h98;
  localparam logic [7:0] ADR_KEY     = 8'h9C;
  localparam logic [7:0] ADR_COUNT   = 8'hA0;
  localparam logic [7:0] ADR_REACT   = 8'hA4;
  localparam logic [7:0] ADR_WINDOW  = 8'hA8;

  localparam logic [31:0] START_WORD = 32'hA98559DA;
  localparam logic [31:0] KEY_ARM    = 32'h0000E51A;
  localparam logic [31:0] KEY_FIRE   = 32'h0000A35C;
  localparam logic [31:0] REACT_NMI  = 32'h0000000A;
  localparam logic [31:0] WIN_RESET  = 32'h00000050;

  typedef enum logic {KEY_IDLE, KEY_ARMED} keyState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic run;
    logic load;
  } ctrlStrb_t;

  // window code -> right shift applied to the loaded value
  function automatic logic [2:0] winShift(input logic [31:0] code);
    case (code)
      32'h00000050: winShift = 3'd1;
      32'h00000500: winShift = 3'd2;
      32'h00005000: winShift = 3'd3;
      32'h00050000: winShift = 3'd4;
      32'h00500000: winShift = 3'd5;
      default:      winShift = 3'd1;
    endcase
  endfunction

endpackage

// File: rtl/wdw_datapath.sv
module wdw_datapath
  import wdw_pkg::*;
#(
  parameter int PRELOAD_W    = 12,
  parameter int RELOAD_SHIFT = 13,
  localparam int CNT_W = PRELOAD_W + RELOAD_SHIFT
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlStrb_t            strb,
  input  logic [PRELOAD_W-1:0] preload,
  input  logic [2:0]           winSel,
  output logic [CNT_W-1:0]     count,
  output logic                 inWindow,
  output logic                 expireEvt
);

  logic [CNT_W-1:0] reloadVal;
  logic [CNT_W-1:0] loadedVal;
  logic [CNT_W-1:0] threshold;

  assign reloadVal = {preload, {RELOAD_SHIFT{1'b0}}};
  assign threshold = loadedVal >> winSel;
  assign inWindow  = (count <= threshold);
  assign expireEvt = strb.run && !strb.load && (count == CNT_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count     <= '0;
      loadedVal <= '0;
    end else if (strb.load) begin
      count     <= reloadVal;
      loadedVal <= reloadVal;
    end else if (strb.run && count != '0) begin
      count <= count - CNT_W'(1);
    end
  end

  AST_LOAD_VALUE: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> count == {$past(preload), {RELOAD_SHIFT{1'b0}}}); // R3

  AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (!rstN)
    (strb.run && !strb.load && count != '0) |=> count == $past(count) - CNT_W'(1)); // R3

  AST_HOLD_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (strb.run && !strb.load && count == '0) |=> count == '0); // R8

endmodule

// File: rtl/wdw_ctrl.sv
module wdw_ctrl
  import wdw_pkg::*;
#(
  parameter int PRELOAD_W = 12,
  parameter int CNT_W     = 25
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regWrEn,
  input  logic [7:0]           regAddr,
  input  logic [31:0]          regWrData,
  output logic [31:0]          regRdData,
  input  logic [CNT_W-1:0]     count,
  input  logic                 inWindow,
  input  logic                 expireEvt,
  output ctrlStrb_t            strb,
  output logic [PRELOAD_W-1:0] preload,
  output logic [2:0]           winSel,
  output logic                 resetOut,
  output logic                 nmiOut
);

  logic       running;
  logic       flag;
  logic [31:0] reactReg;
  logic [31:0] winReg;
  keyState_t  keyState;

  logic wrCtrl, wrPreload, wrStatus, wrKey, wrReact, wrWindow;
  logic startHit, fireHit, serviceOk, earlyHit, violation, clearHit, nmiMode;

  assign wrCtrl    = regWrEn && regAddr == ADR_CTRL;
  assign wrPreload = regWrEn && regAddr == ADR_PRELOAD;
  assign wrStatus  = regWrEn && regAddr == ADR_STATUS;
  assign wrKey     = regWrEn && regAddr == ADR_KEY && running;
  assign wrReact   = regWrEn && regAddr == ADR_REACT;
  assign wrWindow  = regWrEn && regAddr == ADR_WINDOW;

  assign startHit  = wrCtrl && !running && regWrData == START_WORD;
  assign fireHit   = wrKey && keyState == KEY_ARMED && regWrData == KEY_FIRE;
  assign serviceOk = fireHit && inWindow;
  assign earlyHit  = fireHit && !inWindow;
  assign violation = earlyHit || expireEvt;
  assign clearHit  = wrStatus && regWrData[1];
  assign nmiMode   = reactReg == REACT_NMI;

  assign strb.run  = running;
  assign strb.load = startHit || serviceOk;
  assign winSel    = winShift(winReg);
  assign resetOut  = flag && !nmiMode;
  assign nmiOut    = flag && nmiMode;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running  <= 1'b0;
      flag     <= 1'b0;
      preload  <= '1;
      reactReg <= '0;
      winReg   <= WIN_RESET;
      keyState <= KEY_IDLE;
    end else begin
      if (startHit)  running  <= 1'b1;
      if (wrPreload) preload  <= regWrData[PRELOAD_W-1:0];
      if (wrReact)   reactReg <= regWrData;
      if (wrWindow)  winReg   <= regWrData;
      if (violation)     flag <= 1'b1;
      else if (clearHit) flag <= 1'b0;
      if (wrKey) begin
        if (keyState == KEY_IDLE && regWrData == KEY_ARM) keyState <= KEY_ARMED;
        else                                              keyState <= KEY_IDLE;
      end
    end
  end

  always_comb begin
    case (regAddr)
      ADR_CTRL:    regRdData = running ? START_WORD : 32'h0;
      ADR_PRELOAD: regRdData = 32'(preload);
      ADR_STATUS:  regRdData = {30'h0, flag, 1'b0};
      ADR_COUNT:   regRdData = 32'(count);
      ADR_REACT:   regRdData = reactReg;
      ADR_WINDOW:  regRdData = winReg;
      default:     regRdData = 32'h0;
    endcase
  end

  AST_RUN_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    running |=> running); // R2

  AST_EXPIRE_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    expireEvt |=> flag); // R8

  AST_EARLY_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    earlyHit |=> flag && $stable(running)); // R7

  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (flag && !(wrStatus && regWrData[1])) |=> flag); // R10

  AST_REACT_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({resetOut, nmiOut})); // R9

endmodule

// File: rtl/win_watchdog.sv
module win_watchdog
  import wdw_pkg::*;
#(
  parameter int PRELOAD_W    = 12,
  parameter int RELOAD_SHIFT = 13
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic [7:0]  regAddr,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData,
  output logic        resetOut,
  output logic        nmiOut
);

  localparam int CNT_W = PRELOAD_W + RELOAD_SHIFT;

  ctrlStrb_t            strb;
  logic [PRELOAD_W-1:0] preload;
  logic [2:0]           winSel;
  logic [CNT_W-1:0]     count;
  logic                 inWindow;
  logic                 expireEvt;

  wdw_ctrl #(.PRELOAD_W(PRELOAD_W), .CNT_W(CNT_W)) ctrl_i (
    .clk(clk), .rstN(rstN),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .count(count), .inWindow(inWindow), .expireEvt(expireEvt),
    .strb(strb), .preload(preload), .winSel(winSel),
    .resetOut(resetOut), .nmiOut(nmiOut)
  );

  wdw_datapath #(.PRELOAD_W(PRELOAD_W), .RELOAD_SHIFT(RELOAD_SHIFT)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .preload(preload), .winSel(winSel),
    .count(count), .inWindow(inWindow), .expireEvt(expireEvt)
  );

endmodule

// File: tb/win_watchdog_tb.sv
`timescale 1ns/10ps
module win_watchdog_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [7:0]  regAddr = 8'h0;
  logic [31:0] regWrData = 32'h0;
  logic [31:0] regRdData;
  logic        resetOut, nmiOut;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  localparam logic [31:0] GO = 32'hA98559DA;
  localparam logic [31:0] ARM = 32'hE51A;
  localparam logic [31:0] FIRE = 32'hA35C;

  always #2.5 clk = ~clk;

  win_watchdog #(.PRELOAD_W(12), .RELOAD_SHIFT(4)) dut_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .resetOut(resetOut), .nmiOut(nmiOut)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // all tasks start and end just after a falling edge
  task automatic rdChk(input string req, input logic [7:0] a, input logic [31:0] exp);
    regAddr = a;
    #0.1;
    chk(req, regRdData, exp);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic doReset();
    rstN = 1'b0;
    idle(2);
    rstN = 1'b1;
    idle(1);
  endtask

  task automatic outChk(input string req, input logic expRst, input logic expNmi);
    #0.1;
    chk({req, " resetOut"}, {31'h0, resetOut}, {31'h0, expRst});
    chk({req, " nmiOut"}, {31'h0, nmiOut}, {31'h0, expNmi});
  endtask

  task automatic t_reset();
    doReset();
    rdChk("R1 ctrl", 8'h90, 0);
    rdChk("R1 status", 8'h98, 0);
    rdChk("R1 count", 8'hA0, 0);
    rdChk("R1 preload", 8'h94, 32'hFFF);
    rdChk("R1 window", 8'hA8, 32'h50);
    rdChk("R1 react", 8'hA4, 0);
    outChk("R1", 0, 0);
  endtask

  task automatic t_start();
    doReset();
    wr(8'h90, 32'h12345678);
    rdChk("R2 wrong word", 8'h90, 0);
    rdChk("R2 wrong word count", 8'hA0, 0);
    wr(8'h94, 32'h1004);
    rdChk("R3 preload mask", 8'h94, 32'h004);
    wr(8'h90, GO);
    rdChk("R2 running", 8'h90, GO);
    rdChk("R3 load", 8'hA0, 64);
    idle(10);
    rdChk("R3 decrement", 8'hA0, 54);
    wr(8'h90, 0);
    rdChk("R2 no stop", 8'h90, GO);
    rdChk("R2 still counting", 8'hA0, 53);
  endtask

  task automatic t_serviceAndEarly();
    doReset();
    wr(8'h94, 4);
    wr(8'h90, GO);
    idle(40);
    wr(8'h9C, ARM);
    wr(8'h9C, FIRE);
    rdChk("R4 reload", 8'hA0, 64);
    rdChk("R4 status", 8'h98, 0);
    wr(8'h9C, ARM);
    wr(8'h9C, FIRE);
    rdChk("R7 no reload", 8'hA0, 62);
    rdChk("R7 flag", 8'h98, 2);
    outChk("R9 reset mode", 1, 0);
    wr(8'h98, 0);
    rdChk("R10 no clear", 8'h98, 2);
    wr(8'h98, 2);
    rdChk("R10 cleared", 8'h98, 0);
    outChk("R10", 0, 0);
  endtask

  task automatic t_badKey();
    doReset();
    wr(8'h9C, ARM);
    wr(8'h9C, FIRE);
    rdChk("R6 stopped count", 8'hA0, 0);
    rdChk("R6 stopped status", 8'h98, 0);
    wr(8'h94, 4);
    wr(8'h90, GO);
    idle(40);
    wr(8'h9C, ARM);
    wr(8'h9C, 32'h1234);
    wr(8'h9C, FIRE);
    rdChk("R6 junk word", 8'hA0, 21);
    wr(8'h9C, ARM);
    wr(8'h9C, ARM);
    wr(8'h9C, FIRE);
    rdChk("R6 double arm", 8'hA0, 18);
    rdChk("R6 status", 8'h98, 0);
    wr(8'h9C, ARM);
    wr(8'h9C, FIRE);
    rdChk("R6 recovered", 8'hA0, 64);
  endtask

  // code: window code; waitN: idle cycles after start; expect reload or violation
  task automatic winCase(input string req, input logic [31:0] code, input int waitN,
                         input bit expOk);
    doReset();
    wr(8'hA8, code);
    wr(8'h94, 4);
    wr(8'h90, GO);
    idle(waitN);
    wr(8'h9C, ARM);
    wr(8'h9C, FIRE);
    if (expOk) begin
      rdChk(req, 8'hA0, 64);
      rdChk(req, 8'h98, 0);
    end else begin
      rdChk(req, 8'hA0, 32'(64 - waitN - 2));
      rdChk(req, 8'h98, 2);
    end
  endtask

  task automatic t_window();
    winCase("R5 25pct above", 32'h500, 46, 0);     // fire sees 17 > 16
    winCase("R5 25pct edge", 32'h500, 47, 1);      // fire sees 16
    winCase("R5 3pct above", 32'h500000, 59, 0);   // fire sees 4 > 2
    winCase("R5 3pct edge", 32'h500000, 61, 1);    // fire sees 2
    winCase("R5 bad code as 50pct", 32'h77, 31, 1); // fire sees 32
    winCase("R5 50pct above", 32'h50, 30, 0);      // fire sees 33
  endtask

  task automatic t_expire();
    doReset();
    wr(8'hA4, 32'hA);
    rdChk("R9 react", 8'hA4, 32'hA);
    wr(8'h94, 1);
    wr(8'h90, GO);
    idle(15);
    rdChk("R8 before", 8'hA0, 1);
    rdChk("R8 before flag", 8'h98, 0);
    outChk("R8 before", 0, 0);
    wr(8'h98, 2);   // clear collides with the expiry edge
    rdChk("R8 zero", 8'hA0, 0);
    rdChk("R10 set wins", 8'h98, 2);
    outChk("R9 nmi mode", 0, 1);
    idle(3);
    rdChk("R8 hold zero", 8'hA0, 0);
    wr(8'h98, 2);
    outChk("R10 nmi clear", 0, 0);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_start();
    t_serviceAndEarly();
    t_badKey();
    t_window();
    t_expire();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog timeout act=running exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule